// File: doc/BRIEF.md
# Edwards Ladder-Step Micro-Operation Sequencer

This block issues, one at a time, the fixed list of micro-operations that makes up one step of a constant-time scalar-multiplication ladder on a twisted Edwards curve in extended coordinates. Each step is a point doubling followed by a point addition. Before a step starts, the surrounding controller has placed the two working points in the HI bank of a two-bank register file. These are U, the point to be doubled, and V, the point added to the doubled result. The sequencer then walks its internal program. For each entry it presents an opcode, a source bank, two source slots, a destination slot and a modulus select to an external modular arithmetic unit. It moves on only when that unit acknowledges.

Every micro-operation reads its operands from one bank and writes into the other. Two-slot copies sit in the program wherever a later operation needs values that were produced in different banks. The doubling forms its E, F, G and H terms with their signs flipped. This leaves the products unchanged. The last two operations copy the sum into whichever accumulator (R0 or R1) the controller chose when it started the step.

The control is a three-state machine. IDLE waits for `step_go`. ISSUE holds the current micro-operation valid until it is acknowledged. DONE raises `step_done` for a single cycle and then returns to IDLE. The transitions are:
- IDLE to ISSUE on `step_go`.
- ISSUE to ISSUE on an acknowledge of any entry except the last.
- ISSUE to DONE on the acknowledge of the last entry.
- DONE to IDLE unconditionally.

Top module: `edw_step_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `uop_valid`, `busy` and `step_done` are 0.
- R2: A `step_go` seen in IDLE starts a step. From the next cycle `busy` is 1 and `uop_valid` presents program entry 0. `acc_sel` is captured at that same edge.
- R3: While `uop_valid` is 1 and `uop_ack` is 0, all micro-operation fields stay unchanged. The program counter advances only on a cycle with both `uop_valid` and `uop_ack` high. An `uop_ack` while `uop_valid` is 0 has no effect.
- R4: Entries 0 to 14 form the doubling, in this order: A=Ux·Ux, B=Uy·Uy, I=Uz·Uz, C=I+I, I=Ux+Uy, D=I·I, H=A+B, E=H−D, G=A−B, F=C+G, copy (G,H) from HI to LO, Sx=E·F, Sy=G·H, St=E·H, Sz=F·G.
  - Opcode encoding: ADD=0, SUB=1, MUL=2, COPY=3.
  - Slot map: A..J = 0..9; U x,y,z,t = 10..13; V = 14..17; S = 18..21; T = 22..25; R0 = 26..29; R1 = 30..33.
  - Result bank per entry: A, B and I go to LO; C goes to HI; the second I goes to LO; D and H go to HI; E goes to LO; G goes to HI; F goes to LO. The S outputs go to HI.
- R5: Entries 15 to 32 form the addition, in this order: I=Sy−Sx, J=Vy+Vx, A=I·J, I=Sy+Sx, J=Vy−Vx, B=I·J, I=Sz·Vt, C=I+I, I=St·Vz, D=I+I, E=C+D, F=B−A, G=B+A, H=D−C, Tx=E·F, Ty=G·H, Tt=E·H, Tz=F·G.
  - The first operand is always read as source A.
- R6: Entries 33 and 34 are copies from HI. Entry 33 copies Tx,Ty and entry 34 copies Tz,Tt. They go into the x,y and z,t slots of R0 when the captured `acc_sel` is 0, and of R1 when it is 1.
  - A copy moves source A to `uop_dst` and source B to `uop_dst`+1.
- R7: Every entry writes the bank opposite to its `uop_bank` field (0 = LO, 1 = HI). For a copy, the destination is given by the other bank.
- R8: Every issued entry carries `uop_mod` = 1, which selects the 2P modulus.
- R9: `step_done` is 1 for exactly one cycle, in the cycle after the acknowledge of entry 34. In the following cycle `busy` is 0.
- R10: A `step_go` while `busy` is 1 is ignored. The sequence neither restarts nor changes its accumulator, even if `acc_sel` differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_go | input | 1 | Start one ladder step (taken in IDLE only) |
| acc_sel | input | 1 | Accumulator that receives the result: 0 = R0, 1 = R1 |
| uop_ack | input | 1 | Arithmetic unit has completed the presented entry |
| uop_valid | output | 1 | A micro-operation is presented |
| uop_op | output | 2 | Opcode: ADD=0, SUB=1, MUL=2, COPY=3 |
| uop_bank | output | 1 | Source bank: 0 = LO, 1 = HI |
| uop_src_a | output | SLOT_W | First source slot |
| uop_src_b | output | SLOT_W | Second source slot |
| uop_dst | output | SLOT_W | Destination slot in the opposite bank |
| uop_mod | output | 1 | Modulus select, 1 = 2P |
| busy | output | 1 | A step is in progress |
| step_done | output | 1 | One-cycle pulse at the end of a step |

## Verification
The bench builds the block with its default `SLOT_W` of 6, which is enough to hold the 34-slot map, so every slot number the program uses appears on the ports without truncation. The acknowledge is drawn from a seeded random source, which puts stalls of varied length on every program entry and so exercises the hold-stable rule at every position. Directed runs acknowledge every cycle to test the fastest path, target each accumulator, and place a second start with a flipped accumulator select in the middle of a step.

// File: rtl/edw_step_pkg.sv
package edw_step_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_CPY = 2'd3
    } uop_op_e;

    localparam logic BK_LO = 1'b0;
    localparam logic BK_HI = 1'b1;
    localparam logic MOD_2P = 1'b1;

    localparam int SLOT_FIELD_W = 8;
    localparam int NUM_UOPS     = 35;
    localparam int PC_W         = $clog2(NUM_UOPS);

    // scratch terms
    localparam int S_A = 0;
    localparam int S_B = 1;
    localparam int S_C = 2;
    localparam int S_D = 3;
    localparam int S_E = 4;
    localparam int S_F = 5;
    localparam int S_G = 6;
    localparam int S_H = 7;
    localparam int S_I = 8;
    localparam int S_J = 9;
    // point slots, x,y,z,t consecutive
    localparam int S_UX  = 10;
    localparam int S_VX  = 14;
    localparam int S_SX  = 18;
    localparam int S_TX  = 22;
    localparam int S_R0X = 26;
    localparam int S_R1X = 30;

    typedef struct packed {
        uop_op_e                 op;
        logic                    bank;
        logic [SLOT_FIELD_W-1:0] a;
        logic [SLOT_FIELD_W-1:0] b;
        logic [SLOT_FIELD_W-1:0] d;
        logic                    md;
    } uop_t;

    function automatic uop_t mk(input uop_op_e op, input logic bank,
                                input int a, input int b, input int d);
        uop_t u;
        u.op   = op;
        u.bank = bank;
        u.a    = SLOT_FIELD_W'(a);
        u.b    = SLOT_FIELD_W'(b);
        u.d    = SLOT_FIELD_W'(d);
        u.md   = MOD_2P;
        return u;
    endfunction

endpackage

// File: rtl/edw_step_rom.sv
module edw_step_rom
    import edw_step_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic [PC_W-1:0] pc,
    input  logic            acc,
    output uop_op_e         op,
    output logic            bank,
    output logic [SLOT_W-1:0] src_a,
    output logic [SLOT_W-1:0] src_b,
    output logic [SLOT_W-1:0] dst,
    output logic            md
);
    localparam int UY = S_UX + 1, UZ = S_UX + 2;
    localparam int VY = S_VX + 1, VZ = S_VX + 2, VT = S_VX + 3;
    localparam int SY = S_SX + 1, SZ = S_SX + 2, ST = S_SX + 3;
    localparam int TZ = S_TX + 2, TT = S_TX + 3, TY = S_TX + 1;

    uop_t w;
    int   rbase;

    always_comb begin
        rbase = acc ? S_R1X : S_R0X;
        unique case (pc)
            // point doubling of U into S
            6'd0:  w = mk(OP_MUL, BK_HI, S_UX, S_UX, S_A);
            6'd1:  w = mk(OP_MUL, BK_HI, UY,   UY,   S_B);
            6'd2:  w = mk(OP_MUL, BK_HI, UZ,   UZ,   S_I);
            6'd3:  w = mk(OP_ADD, BK_LO, S_I,  S_I,  S_C);
            6'd4:  w = mk(OP_ADD, BK_HI, S_UX, UY,   S_I);
            6'd5:  w = mk(OP_MUL, BK_LO, S_I,  S_I,  S_D);
            6'd6:  w = mk(OP_ADD, BK_LO, S_A,  S_B,  S_H);
            6'd7:  w = mk(OP_SUB, BK_HI, S_H,  S_D,  S_E);
            6'd8:  w = mk(OP_SUB, BK_LO, S_A,  S_B,  S_G);
            6'd9:  w = mk(OP_ADD, BK_HI, S_C,  S_G,  S_F);
            6'd10: w = mk(OP_CPY, BK_HI, S_G,  S_H,  S_G);
            6'd11: w = mk(OP_MUL, BK_LO, S_E,  S_F,  S_SX);
            6'd12: w = mk(OP_MUL, BK_LO, S_G,  S_H,  SY);
            6'd13: w = mk(OP_MUL, BK_LO, S_E,  S_H,  ST);
            6'd14: w = mk(OP_MUL, BK_LO, S_F,  S_G,  SZ);
            // point addition S + V into T
            6'd15: w = mk(OP_SUB, BK_HI, SY,   S_SX, S_I);
            6'd16: w = mk(OP_ADD, BK_HI, VY,   S_VX, S_J);
            6'd17: w = mk(OP_MUL, BK_LO, S_I,  S_J,  S_A);
            6'd18: w = mk(OP_ADD, BK_HI, SY,   S_SX, S_I);
            6'd19: w = mk(OP_SUB, BK_HI, VY,   S_VX, S_J);
            6'd20: w = mk(OP_MUL, BK_LO, S_I,  S_J,  S_B);
            6'd21: w = mk(OP_MUL, BK_HI, SZ,   VT,   S_I);
            6'd22: w = mk(OP_ADD, BK_LO, S_I,  S_I,  S_C);
            6'd23: w = mk(OP_MUL, BK_HI, ST,   VZ,   S_I);
            6'd24: w = mk(OP_ADD, BK_LO, S_I,  S_I,  S_D);
            6'd25: w = mk(OP_ADD, BK_HI, S_C,  S_D,  S_E);
            6'd26: w = mk(OP_SUB, BK_HI, S_B,  S_A,  S_F);
            6'd27: w = mk(OP_ADD, BK_HI, S_B,  S_A,  S_G);
            6'd28: w = mk(OP_SUB, BK_HI, S_D,  S_C,  S_H);
            6'd29: w = mk(OP_MUL, BK_LO, S_E,  S_F,  S_TX);
            6'd30: w = mk(OP_MUL, BK_LO, S_G,  S_H,  TY);
            6'd31: w = mk(OP_MUL, BK_LO, S_E,  S_H,  TT);
            6'd32: w = mk(OP_MUL, BK_LO, S_F,  S_G,  TZ);
            // write back into the selected accumulator
            6'd33: w = mk(OP_CPY, BK_HI, S_TX, TY,   rbase);
            6'd34: w = mk(OP_CPY, BK_HI, TZ,   TT,   rbase + 2);
            default: w = mk(OP_CPY, BK_HI, S_A, S_A, S_A);
        endcase
        op    = w.op;
        bank  = w.bank;
        src_a = w.a[SLOT_W-1:0];
        src_b = w.b[SLOT_W-1:0];
        dst   = w.d[SLOT_W-1:0];
        md    = w.md;
    end

    logic unused_hi;
    assign unused_hi = ^{w.a[SLOT_FIELD_W-1:SLOT_W], w.b[SLOT_FIELD_W-1:SLOT_W],
                         w.d[SLOT_FIELD_W-1:SLOT_W]};
endmodule

// File: rtl/edw_step_fsm.sv
module edw_step_fsm
    import edw_step_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_go,
    input  logic            acc_sel,
    input  logic            uop_ack,
    output logic [PC_W-1:0] pc,
    output logic            acc_q,
    output logic            uop_valid,
    output logic            busy,
    output logic            step_done
);
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } state_e;

    localparam logic [PC_W-1:0] PC_LAST = PC_W'(NUM_UOPS - 1);

    state_e state, state_nx;
    logic   fire;

    assign fire = (state == ST_ISSUE) && uop_ack;

    // state register, program counter and captured accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            acc_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && step_go) begin
                pc    <= '0;
                acc_q <= acc_sel;
            end else if (fire && pc != PC_LAST) begin
                pc <= pc + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (step_go) state_nx = ST_ISSUE;
            ST_ISSUE: if (fire && pc == PC_LAST) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        uop_valid = 1'b0;
        busy      = 1'b0;
        step_done = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: begin uop_valid = 1'b1; busy = 1'b1; end
            ST_DONE:  step_done = 1'b1;
            default:  ;
        endcase
    end

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(acc_q));

    // R3
    pc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && !uop_ack) |=> $stable(pc));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> (!step_done && !busy));
endmodule

// File: rtl/edw_step_seq.sv
module edw_step_seq
    import edw_step_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_go,
    input  logic              acc_sel,
    input  logic              uop_ack,
    output logic              uop_valid,
    output logic [1:0]        uop_op,
    output logic              uop_bank,
    output logic [SLOT_W-1:0] uop_src_a,
    output logic [SLOT_W-1:0] uop_src_b,
    output logic [SLOT_W-1:0] uop_dst,
    output logic              uop_mod,
    output logic              busy,
    output logic              step_done
);
    logic [PC_W-1:0] pc;
    logic            acc_q;
    uop_op_e         op_e;

    edw_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_go   (step_go),
        .acc_sel   (acc_sel),
        .uop_ack   (uop_ack),
        .pc        (pc),
        .acc_q     (acc_q),
        .uop_valid (uop_valid),
        .busy      (busy),
        .step_done (step_done)
    );

    edw_step_rom #(.SLOT_W(SLOT_W)) u_rom (
        .pc    (pc),
        .acc   (acc_q),
        .op    (op_e),
        .bank  (uop_bank),
        .src_a (uop_src_a),
        .src_b (uop_src_b),
        .dst   (uop_dst),
        .md    (uop_mod)
    );

    assign uop_op = op_e;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ack) |=> (uop_valid &&
            $stable({uop_op, uop_bank, uop_src_a, uop_src_b, uop_dst, uop_mod})));

    // R8
    mod_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> uop_mod);

    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_done) |-> $past(uop_valid && uop_ack));

    // R2
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> busy);
endmodule

// File: tb/edw_step_seq_tb.sv
module edw_step_seq_tb;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_go = 1'b0;
    logic acc_sel = 1'b0;
    logic uop_ack = 1'b0;
    logic uop_valid, uop_bank, uop_mod, busy, step_done;
    logic [1:0] uop_op;
    logic [SW-1:0] uop_src_a, uop_src_b, uop_dst;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    edw_step_seq #(.SLOT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .acc_sel(acc_sel),
        .uop_ack(uop_ack), .uop_valid(uop_valid), .uop_op(uop_op),
        .uop_bank(uop_bank), .uop_src_a(uop_src_a), .uop_src_b(uop_src_b),
        .uop_dst(uop_dst), .uop_mod(uop_mod), .busy(busy), .step_done(step_done)
    );

    // expected entry: {op[1:0], bank, a[5:0], b[5:0], d[5:0]}
    function automatic logic [20:0] e(input int op, input int bk,
                                      input int a, input int b, input int d);
        return {2'(op), 1'(bk), 6'(a), 6'(b), 6'(d)};
    endfunction

    // R4 R5 R6 program per the requirement text; ADD0 SUB1 MUL2 CPY3, LO0 HI1
    function automatic logic [20:0] expect_uop(input int i, input logic acc);
        int r;
        r = acc ? 30 : 26;
        case (i)
            0:  return e(2,1,10,10,0);  1:  return e(2,1,11,11,1);
            2:  return e(2,1,12,12,8);  3:  return e(0,0,8,8,2);
            4:  return e(0,1,10,11,8);  5:  return e(2,0,8,8,3);
            6:  return e(0,0,0,1,7);    7:  return e(1,1,7,3,4);
            8:  return e(1,0,0,1,6);    9:  return e(0,1,2,6,5);
            10: return e(3,1,6,7,6);    11: return e(2,0,4,5,18);
            12: return e(2,0,6,7,19);   13: return e(2,0,4,7,21);
            14: return e(2,0,5,6,20);
            15: return e(1,1,19,18,8);  16: return e(0,1,15,14,9);
            17: return e(2,0,8,9,0);    18: return e(0,1,19,18,8);
            19: return e(1,1,15,14,9);  20: return e(2,0,8,9,1);
            21: return e(2,1,20,17,8);  22: return e(0,0,8,8,2);
            23: return e(2,1,21,16,8);  24: return e(0,0,8,8,3);
            25: return e(0,1,2,3,4);    26: return e(1,1,1,0,5);
            27: return e(0,1,1,0,6);    28: return e(1,1,3,2,7);
            29: return e(2,0,4,5,22);   30: return e(2,0,6,7,23);
            31: return e(2,0,4,7,25);   32: return e(2,0,5,6,24);
            33: return e(3,1,22,23,r);  34: return e(3,1,24,25,r+2);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input int i);
        if (i < 15) return "R4";
        if (i < 33) return "R5";
        return "R6";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one full step; mode 0 random ack, 1 ack every cycle; inject a second start mid-step
    task automatic run_step(input logic acc, input int mode, input bit inject);
        int idx = 0;
        int guard = 0;
        logic [20:0] got, want;
        @(negedge clk);
        step_go = 1'b1; acc_sel = acc;
        @(negedge clk);
        step_go = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", busy, 1);
        while (idx < 35 && guard < 2000) begin
            guard++;
            step_go = 1'b0;
            if (!uop_valid) begin
                chk(1'b0, "R3", "valid dropped mid-step", uop_valid, 1);
                uop_ack = 1'b0;
            end else begin
                if (inject && idx == 12) begin
                    step_go = 1'b1; acc_sel = ~acc;   // R10
                end
                if (mode == 1 || $urandom_range(0, 2) == 0) begin
                    got  = {uop_op, uop_bank, uop_src_a, uop_src_b, uop_dst};
                    want = expect_uop(idx, acc);
                    chk(got === want, inject ? "R10" : req_of(idx), "entry fields",
                        int'(got), int'(want));
                    chk(uop_bank === want[18], "R7", "source bank", uop_bank, want[18]);
                    chk(uop_mod === 1'b1, "R8", "modulus select", uop_mod, 1);
                    uop_ack = 1'b1;
                    idx++;
                end else begin
                    uop_ack = 1'b0;
                end
            end
            @(negedge clk);
        end
        uop_ack = 1'b0; step_go = 1'b0;
        chk(step_done === 1'b1, "R9", "done pulse", step_done, 1);
        chk(uop_valid === 1'b0, "R9", "valid in done", uop_valid, 0);
        @(negedge clk);
        chk(step_done === 1'b0, "R9", "done width", step_done, 0);
        chk(busy === 1'b0, "R9", "busy after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (4) @(negedge clk);
        chk({uop_valid, busy, step_done} === 3'b000, "R1", "in reset",
            int'({uop_valid, busy, step_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({uop_valid, busy, step_done} === 3'b000, "R1", "after reset",
            int'({uop_valid, busy, step_done}), 0);
        // R3: acknowledge while idle is ignored
        uop_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk({uop_valid, busy} === 2'b00, "R3", "ack in idle", int'({uop_valid, busy}), 0);
        uop_ack = 1'b0;
        // directed: fastest path to each accumulator, then check entry 0 after idle acks
        run_step(1'b0, 1, 1'b0);
        run_step(1'b1, 1, 1'b0);
        // directed: second start with flipped select in the middle
        run_step(1'b0, 0, 1'b1);
        run_step(1'b1, 0, 1'b1);
        // random stalls and accumulators
        for (int k = 0; k < 6; k++) begin
            run_step(1'($urandom_range(0, 1)), 0, 1'b0);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule